// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer attached to a simple single-cycle register port. A 16-bit down-counter is advanced by a tick. The tick comes from two free-running stages: an 8-bit prescaler that divides the peripheral clock by (value + 1), followed by a secondary divider of 16, 32, 64 or 128. If software does not rewrite the live count in time, the counter expires. On expiry the block can raise a one-cycle reset request, set a sticky interrupt, or do both, and it then reloads itself from a reload-data register.

Software keeps the system alive by writing the count register, which loads the counter at once. A stopped watchdog holds its count, so the reload and count values can be set before it is started again. A pending interrupt is dropped by writing 1 to bit 0 of the interrupt-clear register.

Control is held in a small state machine. `ST_HALT` is the state while the run bit is low. `ST_RUN` is the counting state. `ST_EXPIRE` lasts one cycle, during which the reset request is driven and the reload happens. The transitions are:
- halt-to-run: the run bit is set.
- run-to-halt and expire-to-halt: the run bit is cleared.
- run-to-expire: a tick arrives while the counter reads zero and no count write is under way.
- expire-to-run: the run bit is still set.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0x0000_8039 (run set, reset action set, divider select 3, prescaler 0x80). Reload and count both read 0x8000, and both outputs are low.
- R2: The register offsets are 0x0 control, 0x4 reload, 0x8 live count and 0xC interrupt clear. Control fields are bit 0 reset enable, bit 2 interrupt enable, bits 4:3 divider select, bit 5 run and bits 15:8 prescaler; other control bits read 0 (readback mask 0xFF3D). Reload and count keep only the low 16 bits, and offset 0xC reads 0.
- R3: While the run bit is low, the counter holds its value and no reset request or interrupt is produced.
- R4: While running, the counter decrements once every (prescaler + 1) × 2^(4 + divider select) clock cycles. The first decrement lands that many cycles after the write that sets run.
- R5: A write to the count offset loads the counter on that clock edge. It takes priority over a decrement in the same cycle.
- R6: A tick that finds the counter at zero enters `ST_EXPIRE` on that edge. One cycle later the counter holds the reload value.
- R7: The reset request is high for exactly the one `ST_EXPIRE` cycle, and only when bit 0 of the control register is set.
- R8: When bit 2 of the control register is set, expiry sets the interrupt output on the edge that leaves `ST_EXPIRE`. The output stays high until it is cleared.
- R9: Writing a value with bit 0 set to offset 0xC clears the interrupt on that edge. Writing 0 there leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wd_reset_req | output | 1 | One-cycle reset request on expiry |
| wd_irq | output | 1 | Sticky watchdog interrupt |

## Verification
All timing is counted from E0, the clock edge that accepts the write setting run, with P standing for the tick period.
- A count value of N decrements at E(P), E(2P) and so on, and reaches zero at E(N·P).
- The expire state begins at E((N+1)·P). The reset request is visible only between that edge and the next one, and the reload and the interrupt set both land on the following edge.
- Register writes and interrupt clears take effect on the edge that samples the strobe, and reads are combinational.

The bench drives inputs at falling edges and parks the address on the count offset so the live count can be sampled. Each check is placed one cycle before and exactly at its predicted edge, so a result that comes early or late fails.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int BUS_W    = 32;
    localparam int CNT_W    = 16;
    localparam int PRE_W    = 8;
    localparam int DSEL_W   = 2;
    localparam int DIV_LOG0 = 4;

    localparam logic [3:0] OFF_CTRL   = 4'h0;
    localparam logic [3:0] OFF_RELOAD = 4'h4;
    localparam logic [3:0] OFF_COUNT  = 4'h8;
    localparam logic [3:0] OFF_ICLR   = 4'hC;

    localparam int BIT_RSTEN  = 0;
    localparam int BIT_IRQEN  = 2;
    localparam int BIT_DSEL   = 3;
    localparam int BIT_RUN    = 5;
    localparam int BIT_PRE    = 8;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [DSEL_W-1:0] dsel;
        logic              run;
        logic              irq_en;
        logic              rst_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{pre: 8'h80, dsel: 2'd3, run: 1'b1,
                                     irq_en: 1'b0, rst_en: 1'b1};
    localparam logic [CNT_W-1:0] CNT_RESET = 16'h8000;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_RUN    = 2'd1,
        ST_EXPIRE = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = BUS_W,
    parameter int CW     = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CW-1:0]     cnt_live,
    output ctrl_t             ctrl,
    output logic [CW-1:0]     reload,
    output logic              kick,
    output logic [CW-1:0]     kick_val,
    output logic              iclr,
    output logic [DATA_W-1:0] rdata
);

    logic sel_ctrl, sel_reload, sel_count, sel_iclr;

    always_comb begin
        sel_ctrl   = (addr == ADDR_W'(OFF_CTRL));
        sel_reload = (addr == ADDR_W'(OFF_RELOAD));
        sel_count  = (addr == ADDR_W'(OFF_COUNT));
        sel_iclr   = (addr == ADDR_W'(OFF_ICLR));
    end

    // strobes consumed by the counter core
    assign kick     = we && sel_count;
    assign kick_val = wdata[CW-1:0];
    assign iclr     = we && sel_iclr && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl   <= CTRL_RESET;
            reload <= CNT_RESET;
        end else if (we) begin
            if (sel_ctrl) begin
                ctrl.rst_en <= wdata[BIT_RSTEN];
                ctrl.irq_en <= wdata[BIT_IRQEN];
                ctrl.dsel   <= wdata[BIT_DSEL +: DSEL_W];
                ctrl.run    <= wdata[BIT_RUN];
                ctrl.pre    <= wdata[BIT_PRE +: PRE_W];
            end
            if (sel_reload) begin
                reload <= wdata[CW-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata[BIT_RSTEN]            = ctrl.rst_en;
            rdata[BIT_IRQEN]            = ctrl.irq_en;
            rdata[BIT_DSEL +: DSEL_W]   = ctrl.dsel;
            rdata[BIT_RUN]              = ctrl.run;
            rdata[BIT_PRE +: PRE_W]     = ctrl.pre;
        end else if (sel_reload) begin
            rdata[CW-1:0] = reload;
        end else if (sel_count) begin
            rdata[CW-1:0] = cnt_live;
        end
    end

endmodule

// File: rtl/wdog_tick.sv
module wdog_tick
    import wdog_pkg::*;
#(
    parameter int PW   = PRE_W,
    parameter int SW   = DSEL_W,
    parameter int LOG0 = DIV_LOG0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] pre,
    input  logic [SW-1:0] dsel,
    output logic          tick
);

    // divider counter wide enough for the largest selectable ratio
    localparam int DCW = LOG0 + (2 ** SW) - 1;

    logic [PW-1:0]  pcnt;
    logic [DCW-1:0] dcnt;
    logic [DCW:0]   div_ratio;
    logic [DCW-1:0] div_last;
    logic           pre_hit;

    always_comb begin
        div_ratio = (DCW+1)'(1) << (LOG0 + int'(dsel));
        div_last  = div_ratio[DCW-1:0] - {{(DCW-1){1'b0}}, 1'b1};
        pre_hit   = run && (pcnt == pre);
        tick      = pre_hit && (dcnt == div_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
            dcnt <= '0;
        end else if (!run) begin
            pcnt <= '0;
            dcnt <= '0;
        end else if (pre_hit) begin
            pcnt <= '0;
            dcnt <= (dcnt == div_last) ? '0 : dcnt + 1'b1;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          rst_en,
    input  logic          irq_en,
    input  logic          tick,
    input  logic [CW-1:0] reload,
    input  logic          kick,
    input  logic [CW-1:0] kick_val,
    input  logic          iclr,
    output logic [CW-1:0] cnt,
    output logic          rst_req,
    output logic          irq,
    output logic          in_expire
);

    wd_state_e state, state_nx;
    logic      at_zero;

    assign at_zero = (cnt == '0);

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT:   state_nx = run ? ST_RUN : ST_HALT;
            ST_RUN: begin
                if (!run)
                    state_nx = ST_HALT;
                else if (tick && at_zero && !kick)
                    state_nx = ST_EXPIRE;
            end
            ST_EXPIRE: state_nx = run ? ST_RUN : ST_HALT;
            default:   state_nx = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_HALT;
        else
            state <= state_nx;
    end

    // outputs decoded from the state
    always_comb begin
        in_expire = (state == ST_EXPIRE);
        rst_req   = in_expire && rst_en;
    end

    // live counter: a count write wins over reload and decrement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= CNT_RESET;
        else if (kick)
            cnt <= kick_val;
        else if (state == ST_EXPIRE)
            cnt <= reload;
        else if (state == ST_RUN && run && tick && !at_zero)
            cnt <= cnt - 1'b1;
    end

    // sticky interrupt: setting wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (state == ST_EXPIRE && irq_en)
            irq <= 1'b1;
        else if (iclr)
            irq <= 1'b0;
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              wd_reset_req,
    output logic              wd_irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] kick_val;
    logic             kick;
    logic             iclr;
    logic             tick;
    logic             in_expire;

    wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(BUS_W), .CW(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .cnt_live (cnt),
        .ctrl     (ctrl),
        .reload   (reload),
        .kick     (kick),
        .kick_val (kick_val),
        .iclr     (iclr),
        .rdata    (bus_rdata)
    );

    wdog_tick #(.PW(PRE_W), .SW(DSEL_W), .LOG0(DIV_LOG0)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl.run),
        .pre   (ctrl.pre),
        .dsel  (ctrl.dsel),
        .tick  (tick)
    );

    wdog_core #(.CW(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl.run),
        .rst_en    (ctrl.rst_en),
        .irq_en    (ctrl.irq_en),
        .tick      (tick),
        .reload    (reload),
        .kick      (kick),
        .kick_val  (kick_val),
        .iclr      (iclr),
        .cnt       (cnt),
        .rst_req   (wd_reset_req),
        .irq       (wd_irq),
        .in_expire (in_expire)
    );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              wd_reset_req,
    input logic              wd_irq,
    input ctrl_t             ctrl,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload,
    input logic              in_expire
);

    logic cnt_wr, clr_wr;
    assign cnt_wr = bus_we && (bus_addr == ADDR_W'(OFF_COUNT));
    assign clr_wr = bus_we && (bus_addr == ADDR_W'(OFF_ICLR)) && bus_wdata[0];

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !cnt_wr && !in_expire) |=> $stable(cnt)); // R3

    AST_KICK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(bus_wdata[CNT_W-1:0]))); // R5

    AST_EXPIRE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_expire && !cnt_wr) |=> (cnt == $past(reload))); // R6

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_req |=> !wd_reset_req); // R7

    AST_PULSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_req |-> (ctrl.rst_en && in_expire)); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_irq && !clr_wr) |=> wd_irq); // R8

    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !in_expire) |=> !wd_irq); // R9

endmodule

bind wdog_timer wdog_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .wd_reset_req (wd_reset_req),
    .wd_irq       (wd_irq),
    .ctrl         (ctrl),
    .cnt          (cnt),
    .reload       (reload),
    .in_expire    (in_expire)
);

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_REL  = 4'h4;
    localparam logic [3:0] A_CNT  = 4'h8;
    localparam logic [3:0] A_CLR  = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = A_CNT;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_reset_req;
    logic        wd_irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_timer u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .wd_reset_req (wd_reset_req),
        .wd_irq       (wd_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // single write; returns just after the falling edge that follows the write edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = A_CNT; bus_wdata = '0;
        #1;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = A_CNT;
        #1;
    endtask

    task automatic arm(input logic [15:0] n, input logic [31:0] ctl);
        wr(A_CTRL, 32'h0);
        wr(A_REL, {16'h0, n});
        wr(A_CNT, {16'h0, n});
        wr(A_CTRL, ctl);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0000_8039);
        rd(A_REL, v);  chk("R1 reload", v, 32'h8000);
        rd(A_CNT, v);  chk("R1 count", v, 32'h8000);
        chk("R1 outputs", {30'h0, wd_reset_req, wd_irq}, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); chk("R2 ctrl mask", v, 32'h0000_FF3D);
        wr(A_CTRL, 32'h0);
        wr(A_REL, 32'h0001_ABCD);
        rd(A_REL, v);  chk("R2 reload width", v, 32'h0000_ABCD);
        wr(A_CNT, 32'h0001_FFFF);
        rd(A_CNT, v);  chk("R2 count width", v, 32'h0000_FFFF);
        rd(A_CLR, v);  chk("R2 iclr reads zero", v, 32'h0);
    endtask

    task automatic t_halt();
        bit seen = 1'b0;
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h0000_0005);      // actions on, run off
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #1;
            if (wd_reset_req || wd_irq) seen = 1'b1;
        end
        chk("R3 held count", bus_rdata, 32'h0);
        chk("R3 no action", {31'h0, seen}, 32'h0);
    endtask

    // tick period check for one prescaler/divider setting
    task automatic t_period(input int pre, input int sel);
        int p;
        p = (pre + 1) * (16 << sel);
        arm(16'd9, 32'h20 | (pre << 8) | (sel << 3));
        idle(p - 1); chk("R4 before tick", bus_rdata, 32'd9);
        idle(1);     chk("R4 at tick", bus_rdata, 32'd8);
        idle(p - 1); chk("R4 before 2nd tick", bus_rdata, 32'd8);
        idle(1);     chk("R4 at 2nd tick", bus_rdata, 32'd7);
    endtask

    task automatic t_expire_reset();
        arm(16'd2, 32'h0000_0021);      // run + reset action, /16, prescale 1
        idle(47);
        chk("R6 count at zero", bus_rdata, 32'd0);
        chk("R7 no early pulse", {31'h0, wd_reset_req}, 32'h0);
        idle(1);
        chk("R7 pulse high", {31'h0, wd_reset_req}, 32'h1);
        idle(1);
        chk("R7 pulse one cycle", {31'h0, wd_reset_req}, 32'h0);
        chk("R6 reloaded", bus_rdata, 32'd2);
        chk("R8 irq off when disabled", {31'h0, wd_irq}, 32'h0);
    endtask

    task automatic t_irq();
        arm(16'd1, 32'h0000_0024);      // run + interrupt action
        idle(32);
        chk("R7 no pulse when disabled", {31'h0, wd_reset_req}, 32'h0);
        chk("R8 irq not yet", {31'h0, wd_irq}, 32'h0);
        idle(1);
        chk("R8 irq set", {31'h0, wd_irq}, 32'h1);
        wr(A_CLR, 32'h0);
        chk("R9 zero write ignored", {31'h0, wd_irq}, 32'h1);
        idle(5);
        chk("R8 irq sticky", {31'h0, wd_irq}, 32'h1);
        wr(A_CLR, 32'h1);
        chk("R9 cleared", {31'h0, wd_irq}, 32'h0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_kick();
        bit seen = 1'b0;
        arm(16'd3, 32'h0000_0021);      // would expire 64 cycles in
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 40; i++) begin
                @(negedge clk); #1;
                if (wd_reset_req) seen = 1'b1;
            end
            wr(A_CNT, 32'd3);
            chk("R5 kick loads", bus_rdata, 32'd3);
        end
        chk("R5 no expiry while kicked", {31'h0, seen}, 32'h0);
        wr(A_CNT, 32'h0000_1234);
        chk("R5 running load", bus_rdata, 32'h1234);
        wr(A_CTRL, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_regmap();
        t_halt();
        t_period(0, 0);
        t_period(0, 1);
        t_period(0, 2);
        t_period(0, 3);
        t_period(2, 0);
        t_period(1, 1);
        t_expire_reset();
        t_irq();
        t_kick();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule